// File: doc/BRIEF.md
# Dual Auto-Stepping Memory Portal

This block sits on an 8-bit processor's register bus and opens two independent windows, called portals, onto one shared byte-wide extended memory. Each portal owns a 16-bit address, a signed 8-bit step and a latched data byte. Touching a portal's data register by reading or writing it accesses memory at the portal's address. Afterwards the address moves by the sign-extended step, so a program can stream forwards or backwards through memory with no address arithmetic of its own.

The data register is a latch. It is refilled from memory only when the portal's own address bytes are written or when the portal's data register is accessed. A change made through the other portal does not show until the portal is re-addressed. Every memory write also leaves the block as a 32-bit broadcast message, so that remote devices can keep a replica of the memory. A read-only status byte passes through two flow-control flags from a neighbouring serial port.

The memory holds 2^MEM_AW bytes and is selected by the low MEM_AW bits of the 16-bit address. The full 16-bit address is carried in the broadcast.

Top module: `xmem_portal_pair`

## Requirements
- R1: After reset, both portal addresses read 0x00 in both bytes, both step registers read 0x01, a portal data read returns 0x00, and bc_valid is low.
- R2: Offset 0 is the status byte. Bit 7 follows tx_ready, bit 6 follows rx_avail, and bits 5..0 read 0.
- R3: Portal p uses offset 1+4p for data, 2+4p for step, 3+4p for the address low byte and 4+4p for the address high byte. Writing the data offset stores the byte at the portal address. The address then advances by the sign-extended step.
- R4: Reading the data offset returns the latched byte. The address then advances by the step, and the latch holds the byte at the new address from the next cycle on.
- R5: Address arithmetic wraps modulo 65536. Step 0xFF at address 0x0000 gives 0xFFFF, and step 0x01 at 0xFFFF gives 0x0000.
- R6: Writing either address byte reloads that portal's latch from memory at the new address, readable on the next cycle.
- R7: A portal's latch keeps its old value when the same memory byte is written through the other portal, until its own address is written again.
- R8: Every data write raises bc_valid for the following cycle, with bc_msg bits 31..29 = 0, bit 28 = 1, bits 27..24 = 0, bits 23..16 = written byte and bits 15..0 = written address.
- R9: Reads and writes to non-data offsets produce no broadcast.
- R10: Step and address bytes read back as last written or stepped.
- R11: With step 0, a data write leaves the address in place and the latch then returns the byte just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| tx_ready | input | 1 | Transmit FIFO has room |
| rx_avail | input | 1 | Receive FIFO holds data |
| bc_valid | output | 1 | Broadcast message valid, one cycle per memory write |
| bc_msg | output | 32 | Broadcast message |

## Verification
A wrong address or step inside a portal shows up on the very next data write as a wrong address field in bc_msg. It also shows on the next address-byte read. A latch refilled from the wrong place, or at the wrong time, returns a wrong byte on the first data read that follows, one cycle after the triggering access. Stale-latch behaviour is provoked on purpose by writing through one portal and reading through the other. Forward and backward wraps at the ends of the address space are exercised explicitly.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int unsigned XADDR_W  = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned NPORTAL  = 2;
    localparam int unsigned NFIELD   = 4;

    localparam logic [3:0] OFF_STATUS = 4'd0;

    // field index within one portal's register group
    localparam int unsigned F_DATA = 0;
    localparam int unsigned F_STEP = 1;
    localparam int unsigned F_ALO  = 2;
    localparam int unsigned F_AHI  = 3;

    localparam logic [2:0] BC_DEVICE  = 3'd0;
    localparam logic [3:0] BC_CHANNEL = 4'd0;

    typedef struct packed {
        logic acc;      // data register read or write
        logic wr_step;
        logic wr_lo;
        logic wr_hi;
    } portal_cmd_t;

    function automatic logic [3:0] reg_off(input int unsigned p, input int unsigned f);
        return 4'(1 + p * NFIELD + f);
    endfunction

    function automatic logic [31:0] bc_frame(input logic [XADDR_W-1:0] a,
                                             input logic [BYTE_W-1:0] d);
        return {BC_DEVICE, 1'b1, BC_CHANNEL, d, a};
    endfunction

endpackage

// File: rtl/xmem_ram.sv
module xmem_ram
    import xmem_pkg::*;
#(
    parameter int unsigned MEM_AW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << MEM_AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // refill data forwards a same-cycle write so a step of 0 sees new data
    always_comb begin
        if (we && (waddr == raddr)) rdata = wdata;
        else                        rdata = mem[raddr];
    end
endmodule

// File: rtl/xmem_portal.sv
module xmem_portal
    import xmem_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  portal_cmd_t        cmd,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [BYTE_W-1:0]  fill_data,
    output logic [XADDR_W-1:0] addr_q,
    output logic [XADDR_W-1:0] addr_nxt,
    output logic [BYTE_W-1:0]  step_q,
    output logic [BYTE_W-1:0]  latch_q,
    output logic               reload
);
    logic [XADDR_W-1:0] step_ext;

    always_comb begin
        step_ext = {{(XADDR_W-BYTE_W){step_q[BYTE_W-1]}}, step_q};
        addr_nxt = addr_q;
        if (cmd.acc)   addr_nxt = addr_q + step_ext;
        if (cmd.wr_lo) addr_nxt[BYTE_W-1:0] = wdata;
        if (cmd.wr_hi) addr_nxt[XADDR_W-1:BYTE_W] = wdata;
        reload = cmd.acc | cmd.wr_lo | cmd.wr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            step_q  <= BYTE_W'(1);
            latch_q <= '0;
        end else begin
            addr_q <= addr_nxt;
            if (cmd.wr_step) step_q  <= wdata;
            if (reload)      latch_q <= fill_data;
        end
    end
endmodule

// File: rtl/xmem_bcast.sv
module xmem_bcast
    import xmem_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [XADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic               bc_valid,
    output logic [31:0]        bc_msg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bc_valid <= 1'b0;
            bc_msg   <= '0;
        end else begin
            bc_valid <= wr;
            if (wr) bc_msg <= bc_frame(waddr, wdata);
        end
    end
endmodule

// File: rtl/xmem_portal_pair.sv
module xmem_portal_pair
    import xmem_pkg::*;
#(
    parameter int unsigned MEM_AW = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [3:0]  bus_off,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        tx_ready,
    input  logic        rx_avail,
    output logic        bc_valid,
    output logic [31:0] bc_msg
);
    portal_cmd_t                       cmd     [NPORTAL];
    logic [NPORTAL-1:0]                wr_data;
    logic [NPORTAL-1:0]                reload;
    logic [NPORTAL-1:0][XADDR_W-1:0]   prt_addr;
    logic [NPORTAL-1:0][XADDR_W-1:0]   prt_nxt;
    logic [NPORTAL-1:0][BYTE_W-1:0]    prt_step;
    logic [NPORTAL-1:0][BYTE_W-1:0]    prt_latch;

    logic                ram_we;
    logic [XADDR_W-1:0]  ram_waddr;
    logic [XADDR_W-1:0]  ram_raddr;
    logic [BYTE_W-1:0]   fill_data;

    for (genvar p = 0; p < NPORTAL; p++) begin : g_portal
        always_comb begin
            cmd[p].acc     = bus_en && (bus_off == reg_off(p, F_DATA));
            cmd[p].wr_step = bus_en && bus_we && (bus_off == reg_off(p, F_STEP));
            cmd[p].wr_lo   = bus_en && bus_we && (bus_off == reg_off(p, F_ALO));
            cmd[p].wr_hi   = bus_en && bus_we && (bus_off == reg_off(p, F_AHI));
            wr_data[p]     = cmd[p].acc && bus_we;
        end

        xmem_portal u_portal (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd[p]),
            .wdata     (bus_wdata),
            .fill_data (fill_data),
            .addr_q    (prt_addr[p]),
            .addr_nxt  (prt_nxt[p]),
            .step_q    (prt_step[p]),
            .latch_q   (prt_latch[p]),
            .reload    (reload[p])
        );
    end

    // one bus access per cycle; portal 1 takes precedence if both ever fire
    always_comb begin
        ram_we    = |wr_data;
        ram_waddr = wr_data[1] ? prt_addr[1] : prt_addr[0];
        ram_raddr = reload[1]  ? prt_nxt[1]  : prt_nxt[0];
    end

    xmem_ram #(.MEM_AW(MEM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr[MEM_AW-1:0]),
        .wdata (bus_wdata),
        .raddr (ram_raddr[MEM_AW-1:0]),
        .rdata (fill_data)
    );

    xmem_bcast u_bcast (
        .clk      (clk),
        .rst      (rst),
        .wr       (ram_we),
        .waddr    (ram_waddr),
        .wdata    (bus_wdata),
        .bc_valid (bc_valid),
        .bc_msg   (bc_msg)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_off == OFF_STATUS) bus_rdata = {tx_ready, rx_avail, 6'b0};
        for (int p = 0; p < NPORTAL; p++) begin
            if (bus_off == reg_off(p, F_DATA)) bus_rdata = prt_latch[p];
            if (bus_off == reg_off(p, F_STEP)) bus_rdata = prt_step[p];
            if (bus_off == reg_off(p, F_ALO))  bus_rdata = prt_addr[p][BYTE_W-1:0];
            if (bus_off == reg_off(p, F_AHI))  bus_rdata = prt_addr[p][XADDR_W-1:BYTE_W];
        end
    end
endmodule

// File: rtl/xmem_portal_chk.sv
module xmem_portal_chk
    import xmem_pkg::*;
(
    input logic                              clk,
    input logic                              rst,
    input logic                              bus_en,
    input logic                              bus_we,
    input logic [3:0]                        bus_off,
    input logic [7:0]                        bus_wdata,
    input logic [7:0]                        bus_rdata,
    input logic                              tx_ready,
    input logic                              rx_avail,
    input logic                              bc_valid,
    input logic [31:0]                       bc_msg,
    input logic [NPORTAL-1:0][XADDR_W-1:0]   prt_addr,
    input logic [NPORTAL-1:0][BYTE_W-1:0]    prt_step
);
    logic dw0, dw1, ac0, ac1;
    always_comb begin
        ac0 = bus_en && (bus_off == reg_off(0, F_DATA));
        ac1 = bus_en && (bus_off == reg_off(1, F_DATA));
        dw0 = ac0 && bus_we;
        dw1 = ac1 && bus_we;
    end

    // R2
    status_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_off == OFF_STATUS) |->
        (bus_rdata[7] == tx_ready && bus_rdata[6] == rx_avail && bus_rdata[5:0] == 6'b0));

    // R9
    bc_only_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> $past(dw0 || dw1));

    // R8
    bc_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dw0 || dw1) |=> (bc_valid && bc_msg[31:24] == 8'h10 && bc_msg[23:16] == $past(bus_wdata)));

    // R3
    addr0_step_chk: assert property (@(posedge clk) disable iff (rst)
        ac0 |=> prt_addr[0] == $past(prt_addr[0])
                 + {{(XADDR_W-BYTE_W){$past(prt_step[0][7])}}, $past(prt_step[0])});

    // R4
    addr1_step_chk: assert property (@(posedge clk) disable iff (rst)
        ac1 |=> prt_addr[1] == $past(prt_addr[1])
                 + {{(XADDR_W-BYTE_W){$past(prt_step[1][7])}}, $past(prt_step[1])});

    // R10
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_we && (bus_off == reg_off(0, F_STEP) || bus_off == reg_off(1, F_STEP)))
        |=> $stable(prt_step));
endmodule

bind xmem_portal_pair xmem_portal_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_off   (bus_off),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_ready  (tx_ready),
    .rx_avail  (rx_avail),
    .bc_valid  (bc_valid),
    .bc_msg    (bc_msg),
    .prt_addr  (prt_addr),
    .prt_step  (prt_step)
);

// File: tb/xmem_portal_pair_tb_top.sv
module xmem_portal_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_off = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tx_ready = 1'b0;
    logic        rx_avail = 1'b0;
    logic        bc_valid;
    logic [31:0] bc_msg;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xmem_portal_pair dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_ready(tx_ready),
        .rx_avail(rx_avail), .bc_valid(bc_valid), .bc_msg(bc_msg)
    );

    // offsets: portal0 data1 step2 lo3 hi4, portal1 data5 step6 lo7 hi8
    // entry = {we, off, wdata, expect}; expect is read data, or low address byte of a data write
    localparam int NV = 27;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'd3, 8'h10, 8'h00},  // R6 addr0 lo
        {1'b1, 4'd4, 8'h00, 8'h00},  // R6 addr0 hi
        {1'b1, 4'd1, 8'hA1, 8'h10},  // R3 R8 write @0010
        {1'b1, 4'd1, 8'hA2, 8'h11},  // R3
        {1'b1, 4'd1, 8'hA3, 8'h12},  // R3
        {1'b0, 4'd3, 8'h00, 8'h13},  // R10 address advanced by 3
        {1'b1, 4'd2, 8'hFF, 8'h00},  // step0 = -1
        {1'b1, 4'd3, 8'h12, 8'h00},  // R6 re-address
        {1'b0, 4'd1, 8'h00, 8'hA3},  // R4 backwards stream
        {1'b0, 4'd1, 8'h00, 8'hA2},
        {1'b0, 4'd1, 8'h00, 8'hA1},
        {1'b0, 4'd3, 8'h00, 8'h0F},  // R5 stepped down
        {1'b0, 4'd2, 8'h00, 8'hFF},  // R10 step readback
        {1'b1, 4'd8, 8'h00, 8'h00},  // addr1 hi
        {1'b1, 4'd7, 8'h11, 8'h00},  // R6 addr1 lo -> latch mem[11]
        {1'b0, 4'd5, 8'h00, 8'hA2},  // R4 portal1 same memory
        {1'b0, 4'd5, 8'h00, 8'hA3},
        {1'b0, 4'd7, 8'h00, 8'h13},  // R10
        {1'b1, 4'd3, 8'h20, 8'h00},
        {1'b1, 4'd1, 8'h55, 8'h20},  // R8 write @0020
        {1'b1, 4'd7, 8'h20, 8'h00},  // latch1 = 55
        {1'b1, 4'd3, 8'h20, 8'h00},
        {1'b1, 4'd1, 8'h66, 8'h20},  // overwrite via portal0
        {1'b0, 4'd5, 8'h00, 8'h55},  // R7 stale
        {1'b1, 4'd7, 8'h20, 8'h00},  // R6 re-address refreshes
        {1'b0, 4'd5, 8'h00, 8'h66},  // R7
        {1'b0, 4'd7, 8'h00, 8'h21}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic [3:0] off, input logic [7:0] wd,
                      input logic [7:0] ex, input logic [7:0] ahi, input string req);
        logic dw;
        dw = we && (off == 4'd1 || off == 4'd5);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_off = off; bus_wdata = wd;
        #1;
        if (!we) chk(bus_rdata == ex, req, {24'h0, bus_rdata}, {24'h0, ex});
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
        if (dw) chk(bc_valid && bc_msg == {8'h10, wd, ahi, ex}, "R8",
                    {bc_msg[31:1], bc_valid}, {8'h10, wd, ahi, ex[7:1], 1'b1});
        else    chk(!bc_valid, "R9", {31'h0, bc_valid}, 32'h0);
    endtask

    task automatic rd_status(input logic t, input logic r);
        @(negedge clk);
        tx_ready = t; rx_avail = r; bus_off = 4'd0;
        #1;
        chk(bus_rdata == {t, r, 6'b0}, "R2", {24'h0, bus_rdata}, {24'h0, t, r, 6'b0});
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        op(1'b0, 4'd3, 8'h00, 8'h00, 8'h00, "R1");
        op(1'b0, 4'd4, 8'h00, 8'h00, 8'h00, "R1");
        op(1'b0, 4'd2, 8'h00, 8'h01, 8'h00, "R1");
        op(1'b0, 4'd6, 8'h00, 8'h01, 8'h00, "R1");
        op(1'b0, 4'd5, 8'h00, 8'h00, 8'h00, "R1");
        // R2 status pass-through
        rd_status(1'b1, 1'b0);
        rd_status(1'b0, 1'b1);
        rd_status(1'b1, 1'b1);
        rd_status(1'b0, 1'b0);
        // table walk: R3 R4 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            op(VEC[i][20], VEC[i][19:16], VEC[i][15:8], VEC[i][7:0], 8'h00,
               VEC[i][20] ? "R3" : "R4");
        end
        // R5 wrap backwards then forwards
        op(1'b1, 4'd3, 8'h00, 8'h00, 8'h00, "R5");
        op(1'b1, 4'd4, 8'h00, 8'h00, 8'h00, "R5");
        op(1'b1, 4'd2, 8'hFF, 8'h00, 8'h00, "R5");
        op(1'b1, 4'd1, 8'h77, 8'h00, 8'h00, "R5");
        op(1'b0, 4'd3, 8'h00, 8'hFF, 8'h00, "R5");
        op(1'b0, 4'd4, 8'h00, 8'hFF, 8'h00, "R5");
        op(1'b1, 4'd2, 8'h01, 8'h00, 8'h00, "R5");
        op(1'b1, 4'd1, 8'h88, 8'hFF, 8'hFF, "R5");
        op(1'b0, 4'd4, 8'h00, 8'h00, 8'h00, "R5");
        op(1'b0, 4'd3, 8'h00, 8'h00, 8'h00, "R5");
        // R11 zero step
        op(1'b1, 4'd6, 8'h00, 8'h00, 8'h00, "R11");
        op(1'b1, 4'd8, 8'h00, 8'h00, 8'h00, "R11");
        op(1'b1, 4'd7, 8'h40, 8'h00, 8'h00, "R11");
        op(1'b1, 4'd5, 8'h5A, 8'h40, 8'h00, "R11");
        op(1'b0, 4'd5, 8'h00, 8'h5A, 8'h00, "R11");
        op(1'b0, 4'd7, 8'h00, 8'h40, 8'h00, "R11");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule